// File: doc/BRIEF.md
# Windowed Watchdog with Dual Reset Outputs

This block supervises a microcontroller through trigger commands decoded from its serial interface and drives two active-low reset lines. Once the supplies are reported good, the main reset is held low for a fixed hold time. It is then released, and the controller must deliver a first trigger inside a fixed first window. That first trigger releases the auxiliary reset. From then on, triggers must come periodically, each one inside a window covering the last quarter of a programmable period.

The period is chosen by a 3-bit prescaler code. The code may be written once only, in a short configuration window that opens at the first trigger. Two consecutive trigger commands must be separated by at least one other serial command. An early trigger, a missing trigger, an unseparated trigger or an overvoltage flag is a fault. A fault pulls both resets low, returns the prescaler to its default and restarts the sequence from the hold.

All timing is counted in pulses of `ms_tick`, which is a one-cycle pulse per millisecond from the surrounding time base.

Top module: `wdt_window_reset`

## Requirements
- R1: After `rst_n` is released, with `supplies_ok` low, `rst_main_n` and `rst_aux_n` are 0 and `presc_code` is 3'b011 (the 16 ms default).
- R2: After `supplies_ok` goes high, `rst_main_n` stays 0 through 15 ticks and is 1 in the cycle after the 16th tick. `rst_aux_n` stays 0.
- R3: Counting ticks from the rise of `rst_main_n`:
  - a trigger after fewer than 12 ticks is a fault;
  - a trigger after 12 to 19 ticks is valid and sets `rst_aux_n` to 1 in the next cycle.
- R4: If no trigger arrives, the 20th tick after the rise of `rst_main_n` is a fault.
- R5: `presc_code` selects the period: 001=4, 010=8, 011=16, 100=32, 101=64 and 110=128 ticks. A written 000 or 111 is stored as 011 (16 ticks).
- R6: A prescaler write is accepted only between the valid first trigger and the first tick after it, and only the first such write is accepted. Any other write leaves `presc_code` unchanged.
- R7: In the periodic phase with period P, ticks are counted from the last valid trigger:
  - a trigger after fewer than 3P/4 ticks is a fault;
  - a trigger after 3P/4 to P-1 ticks is valid and restarts the count;
  - reaching P ticks without a trigger is a fault.
- R8: A trigger is valid only if an `other_cmd` pulse was seen since the previous trigger. The first trigger after each hold needs none. An unseparated trigger is a fault.
- R9: While `overvolt` is high and the supplies are good, both resets are 0. After `overvolt` falls, the full 16-tick hold starts again.
- R10: A fault drives both resets to 0 in the next cycle, restores `presc_code` to 3'b011 and restarts the hold.
- R11: When `supplies_ok` falls, both resets go to 0 in the next cycle and `presc_code` returns to 3'b011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| supplies_ok | input | 1 | All monitored supplies are good |
| overvolt | input | 1 | Overvoltage on core or peripheral supply |
| trig_cmd | input | 1 | Decoded watchdog trigger command pulse |
| other_cmd | input | 1 | Decoded pulse for any other serial command |
| cfg_wr | input | 1 | Prescaler configuration command pulse |
| cfg_sel | input | 3 | Prescaler code carried by the command |
| rst_main_n | output | 1 | Main reset, active low |
| rst_aux_n | output | 1 | Secondary reset, active low |
| presc_code | output | 3 | Prescaler code in force |

## Verification
Every input is sampled on one clock edge, and the resets and `presc_code` change at that same edge. A result is therefore due exactly one cycle after the tick, trigger, write or flag that causes it. The bench drives each stimulus for one cycle between falling edges and reads the outputs at the following falling edge. It counts ticks itself, so the window limits are hit to the exact tick: one tick short of each bound, and exactly on it. The periodic-phase timing is checked with random prescaler codes and random trigger positions inside the legal window.

// File: rtl/wdt_pkg.sv
// Package: shared state encoding and prescaler helpers for the windowed watchdog.
// Assumes: code 3'b011 is the default 16-tick period.
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FIRST = 2'd2,
        ST_RUN   = 2'd3
    } wdt_state_t;

    localparam logic [2:0] DEFAULT_CODE = 3'b011;

    // Maps the two reserved codes onto the default period code.
    function automatic logic [2:0] norm_code(input logic [2:0] c);
        return ((c == 3'b000) || (c == 3'b111)) ? DEFAULT_CODE : c;
    endfunction

endpackage

// File: rtl/wdt_presc.sv
// Module: prescaler register. It holds the period code and derives the period
// and the window-open point (3/4 of the period) in ticks.
// Assumes: wr_ok is already qualified by the configuration window.
module wdt_presc
    import wdt_pkg::*;
#(
    parameter int BASE_MS = 4,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restore,
    input  logic             wr_ok,
    input  logic [2:0]       sel,
    output logic [2:0]       code,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] open_at
);

    // Code register: default on reset or fault, updated by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n || restore) begin
            code <= DEFAULT_CODE;
        end else if (wr_ok) begin
            code <= norm_code(sel);
        end
    end

    // Period doubles per code step; the window opens after 3/4 of it.
    always_comb begin
        period  = CNT_W'(BASE_MS) << (code - 3'd1);
        open_at = period - (period >> 2);
    end

    a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (code != 3'b000) && (code != 3'b111));

    a_r10_default_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (code == DEFAULT_CODE));

endmodule

// File: rtl/wdt_cfg_win.sv
// Module: one-shot configuration window. It opens at the valid first trigger
// and closes after CFG_MS ticks or after the first write, whichever is earlier.
// Assumes: start and clear are single-cycle pulses; clear has priority.
module wdt_cfg_win #(
    parameter int CFG_MS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    input  logic used,
    input  logic tick,
    output logic open
);

    localparam int CW = $clog2(CFG_MS + 1);
    localparam logic [CW-1:0] LAST = CW'(CFG_MS - 1);

    logic [CW-1:0] cnt;

    // Window flag and its tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            open <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            open <= 1'b1;
            cnt  <= '0;
        end else if (open && used) begin
            open <= 1'b0;
        end else if (open && tick) begin
            if (cnt == LAST) begin
                open <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r6_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (open && used && !start) |=> !open);

endmodule

// File: rtl/wdt_qual.sv
// Module: trigger separation tracker. It is armed when another serial command
// has been seen since the last trigger, and is re-armed on restore.
// Assumes: restore wins over trig, and trig wins over other.
module wdt_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic restore,
    input  logic trig,
    input  logic other,
    output logic armed
);

    // Arm flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || restore) begin
            armed <= 1'b1;
        end else if (trig) begin
            armed <= 1'b0;
        end else if (other) begin
            armed <= 1'b1;
        end
    end

    a_r8_trig_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !restore) |=> !armed);

endmodule

// File: rtl/wdt_seq.sv
// Module: watchdog sequencer. It runs the phases off, hold, first window and
// periodic, counts ticks in each phase, and detects faults.
// Assumes: tick and trig are single-cycle pulses; the period is at least 4 ticks.
module wdt_seq
    import wdt_pkg::*;
#(
    parameter int HOLD_MS       = 16,
    parameter int FIRST_OPEN_MS = 12,
    parameter int FIRST_LEN_MS  = 8,
    parameter int CNT_W         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supplies_ok,
    input  logic             overvolt,
    input  logic             tick,
    input  logic             trig,
    input  logic             armed,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] open_at,
    output logic             fault,
    output logic             first_pass,
    output logic             main_n,
    output logic             aux_n
);

    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_MS - 1);
    localparam logic [CNT_W-1:0] FIRST_OPEN = CNT_W'(FIRST_OPEN_MS);
    localparam logic [CNT_W-1:0] FIRST_LAST = CNT_W'(FIRST_OPEN_MS + FIRST_LEN_MS - 1);

    wdt_state_t       state;
    logic [CNT_W-1:0] cnt;

    // Fault and first-trigger detection for the current phase.
    always_comb begin
        fault      = 1'b0;
        first_pass = 1'b0;
        case (state)
            ST_FIRST: begin
                if (trig) begin
                    if (armed && (cnt >= FIRST_OPEN)) begin
                        first_pass = 1'b1;
                    end else begin
                        fault = 1'b1;
                    end
                end else if (tick && (cnt == FIRST_LAST)) begin
                    fault = 1'b1;
                end
            end
            ST_RUN: begin
                if (trig) begin
                    if (!(armed && (cnt >= open_at))) begin
                        fault = 1'b1;
                    end
                end else if (tick && (cnt == period - 1'b1)) begin
                    fault = 1'b1;
                end
            end
            default: ;
        endcase
        if (overvolt && (state != ST_OFF)) begin
            fault      = 1'b1;
            first_pass = 1'b0;
        end
    end

    // Phase register and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !supplies_ok) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else if (fault) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else begin
            case (state)
                ST_OFF: begin
                    state <= ST_HOLD;
                    cnt   <= '0;
                end
                ST_HOLD: begin
                    if (tick) begin
                        if (cnt == HOLD_LAST) begin
                            state <= ST_FIRST;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_FIRST: begin
                    if (first_pass) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (trig) begin
                        cnt <= '0;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Reset outputs follow the registered phase.
    always_comb begin
        main_n = (state == ST_FIRST) || (state == ST_RUN);
        aux_n  = (state == ST_RUN);
    end

    a_r2_release_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_n) |-> ($past(tick) && ($past(cnt) == HOLD_LAST)));

    a_r3_aux_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_n) |-> $past(trig));

    a_r4_first_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_FIRST) && tick && !trig && (cnt == FIRST_LAST)) |=> !main_n);

    a_r7_run_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && tick && !trig && (cnt == period - 1'b1)) |=> !aux_n);

    a_r8_unarmed_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == ST_RUN) || (state == ST_FIRST)) && trig && !armed) |=> !main_n);

    a_r9_overvolt_low: assert property (@(posedge clk) disable iff (!rst_n)
        (overvolt && (state != ST_OFF)) |=> (!main_n && !aux_n));

    a_r11_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !supplies_ok |=> (!main_n && !aux_n));

endmodule

// File: rtl/wdt_window_reset.sv
// Module: top of the windowed watchdog. It joins the sequencer, the prescaler,
// the configuration window and the trigger-separation tracker.
// Assumes: all command inputs are single-cycle pulses from a serial decoder,
// and ms_tick is a single-cycle pulse per millisecond.
module wdt_window_reset
    import wdt_pkg::*;
#(
    parameter int HOLD_MS       = 16,
    parameter int FIRST_OPEN_MS = 12,
    parameter int FIRST_LEN_MS  = 8,
    parameter int CFG_MS        = 1,
    parameter int BASE_MS       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       supplies_ok,
    input  logic       overvolt,
    input  logic       trig_cmd,
    input  logic       other_cmd,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_sel,
    output logic       rst_main_n,
    output logic       rst_aux_n,
    output logic [2:0] presc_code
);

    localparam int MAX_A  = (BASE_MS * 32 > HOLD_MS) ? BASE_MS * 32 : HOLD_MS;
    localparam int MAX_MS = (MAX_A > FIRST_OPEN_MS + FIRST_LEN_MS) ? MAX_A
                                                                   : FIRST_OPEN_MS + FIRST_LEN_MS;
    localparam int CNT_W  = $clog2(MAX_MS + 1);

    logic             fault;
    logic             first_pass;
    logic             restore;
    logic             armed;
    logic             cfg_open;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] open_at;

    // A fault or a supply loss returns all configuration to default.
    always_comb begin
        restore = fault || !supplies_ok;
    end

    wdt_seq #(
        .HOLD_MS      (HOLD_MS),
        .FIRST_OPEN_MS(FIRST_OPEN_MS),
        .FIRST_LEN_MS (FIRST_LEN_MS),
        .CNT_W        (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .supplies_ok(supplies_ok),
        .overvolt   (overvolt),
        .tick       (ms_tick),
        .trig       (trig_cmd),
        .armed      (armed),
        .period     (period),
        .open_at    (open_at),
        .fault      (fault),
        .first_pass (first_pass),
        .main_n     (rst_main_n),
        .aux_n      (rst_aux_n)
    );

    wdt_presc #(
        .BASE_MS(BASE_MS),
        .CNT_W  (CNT_W)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .restore(restore),
        .wr_ok  (cfg_wr && cfg_open),
        .sel    (cfg_sel),
        .code   (presc_code),
        .period (period),
        .open_at(open_at)
    );

    wdt_cfg_win #(
        .CFG_MS(CFG_MS)
    ) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .start(first_pass && supplies_ok),
        .clear(restore),
        .used (cfg_wr),
        .tick (ms_tick),
        .open (cfg_open)
    );

    wdt_qual u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .restore(restore),
        .trig   (trig_cmd),
        .other  (other_cmd),
        .armed  (armed)
    );

    a_r6_reject_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_open && !restore) |=> $stable(presc_code));

    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !supplies_ok |=> (presc_code == DEFAULT_CODE));

endmodule

// File: tb/wdt_window_reset_test.sv
// Bench: directed corner cases plus seeded random periodic operation.
module wdt_window_reset_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       supplies_ok = 1'b0;
    logic       overvolt = 1'b0;
    logic       trig_cmd = 1'b0;
    logic       other_cmd = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_sel = 3'b000;
    logic       rst_main_n;
    logic       rst_aux_n;
    logic [2:0] presc_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    wdt_window_reset uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ms_tick    (ms_tick),
        .supplies_ok(supplies_ok),
        .overvolt   (overvolt),
        .trig_cmd   (trig_cmd),
        .other_cmd  (other_cmd),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .rst_main_n (rst_main_n),
        .rst_aux_n  (rst_aux_n),
        .presc_code (presc_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int exp_period(input logic [2:0] c);
        case (c)
            3'b001:  return 4;
            3'b010:  return 8;
            3'b100:  return 32;
            3'b101:  return 64;
            3'b110:  return 128;
            default: return 16;
        endcase
    endfunction

    function automatic logic [2:0] exp_code(input logic [2:0] s);
        return ((s == 3'b000) || (s == 3'b111)) ? 3'b011 : s;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    task automatic trig();
        trig_cmd = 1'b1;
        @(negedge clk);
        trig_cmd = 1'b0;
    endtask

    task automatic other();
        other_cmd = 1'b1;
        @(negedge clk);
        other_cmd = 1'b0;
    endtask

    task automatic cfg(input logic [2:0] s);
        cfg_sel = s;
        cfg_wr  = 1'b1;
        @(negedge clk);
        cfg_wr  = 1'b0;
    endtask

    // Power-up from the off state up to the first trigger after `wait_first` ticks.
    task automatic to_run(input int wait_first);
        supplies_ok = 1'b1;
        @(negedge clk);
        ticks(16);
        ticks(wait_first);
        trig();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 main", int'(rst_main_n), 0);
        chk("R1 aux", int'(rst_aux_n), 0);
        chk("R1 code", int'(presc_code), 3);

        // R2 hold time
        supplies_ok = 1'b1;
        @(negedge clk);
        ticks(15);
        chk("R2 main held", int'(rst_main_n), 0);
        ticks(1);
        chk("R2 main released", int'(rst_main_n), 1);
        chk("R2 aux held", int'(rst_aux_n), 0);

        // R3 early first trigger is a fault (R10 restart)
        ticks(11);
        trig();
        chk("R3 early first", int'(rst_main_n), 0);
        ticks(16);
        chk("R10 hold restarted", int'(rst_main_n), 1);
        ticks(12);
        trig();
        chk("R3 first valid", int'(rst_aux_n), 1);

        // R5/R6 one write inside the configuration window
        cfg(3'b101);
        chk("R5 code 64", int'(presc_code), 5);
        cfg(3'b001);
        chk("R6 second write ignored", int'(presc_code), 5);

        // R7 periodic window with P=64, open after 48 ticks
        other();
        ticks(48);
        trig();
        chk("R7 trigger at 3P/4", int'(rst_aux_n), 1);
        other();
        ticks(47);
        trig();
        chk("R7 early periodic", int'(rst_aux_n), 0);
        chk("R10 code default", int'(presc_code), 3);

        // R6 write after the window closed; R7 missing trigger
        ticks(16);
        ticks(12);
        trig();
        ticks(1);
        cfg(3'b001);
        chk("R6 late write ignored", int'(presc_code), 3);
        ticks(14);
        chk("R7 before deadline", int'(rst_aux_n), 1);
        ticks(1);
        chk("R7 missing trigger", int'(rst_aux_n), 0);

        // R8 trigger without a separating command
        ticks(16);
        ticks(12);
        trig();
        ticks(12);
        trig();
        chk("R8 unseparated trigger", int'(rst_main_n), 0);

        // R4 no first trigger
        ticks(16);
        ticks(19);
        chk("R4 before timeout", int'(rst_main_n), 1);
        ticks(1);
        chk("R4 timeout", int'(rst_main_n), 0);

        // R9 overvoltage
        ticks(16);
        chk("R9 released before flag", int'(rst_main_n), 1);
        overvolt = 1'b1;
        @(negedge clk);
        chk("R9 flag forces low", int'(rst_main_n), 0);
        ticks(20);
        chk("R9 held while flagged", int'(rst_main_n), 0);
        overvolt = 1'b0;
        @(negedge clk);
        ticks(15);
        chk("R9 hold restarted", int'(rst_main_n), 0);
        ticks(1);
        chk("R9 released after hold", int'(rst_main_n), 1);

        // R11 supply loss
        ticks(12);
        trig();
        cfg(3'b010);
        supplies_ok = 1'b0;
        @(negedge clk);
        chk("R11 main low", int'(rst_main_n), 0);
        chk("R11 aux low", int'(rst_aux_n), 0);
        chk("R11 code default", int'(presc_code), 3);

        // Random periodic operation
        for (int round = 0; round < 8; round++) begin
            logic [2:0] s;
            int p;
            int o;
            int kind;
            to_run(12 + int'($urandom % 8));
            chk("R3 random first", int'(rst_aux_n), 1);
            s = 3'($urandom % 8);
            cfg(s);
            chk("R5 random code", int'(presc_code), int'(exp_code(s)));
            p = exp_period(s);
            o = p - p / 4;
            for (int k = 0; k < 3; k++) begin
                other();
                ticks(o + int'($urandom % (p - o)));
                trig();
                chk("R7 random valid", int'(rst_aux_n), 1);
            end
            kind = int'($urandom % 3);
            if (kind == 0) begin
                other();
                ticks(o - 1);
                trig();
                chk("R7 random early", int'(rst_main_n), 0);
            end else if (kind == 1) begin
                ticks(p);
                chk("R7 random missing", int'(rst_main_n), 0);
            end else begin
                ticks(o);
                trig();
                chk("R8 random unseparated", int'(rst_main_n), 0);
            end
            chk("R10 random default", int'(presc_code), 3);
            supplies_ok = 1'b0;
            @(negedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule